// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer

This block is a memory-mapped up-counter. A prescaler divides the input clock so that the counter advances once every (divider + 1) clock cycles while the counter-enable bit is set. When the count equals a non-zero reload limit on an advancing cycle, the counter wraps to zero. If update interrupts are enabled, this wrap also sets a status flag and raises a one-cycle interrupt pulse.

Software reaches the block through a plain register bus with an address, a write strobe, write data and combinational read data. Through it software can enable counting, set the divider and the reload limit, load the count, force the counter back to zero, and clear the status flag. A set of holding registers (four compare values, mode, channel-enable, secondary control, trigger configuration, transfer configuration and option words) is stored and read back only. None of these holding registers drives any logic.

Top module: `arl_timer`

## Requirements
- R1: After reset every mapped register reads zero, the count reads zero and the interrupt output is low.
- R2: With the enable bit (bit 0 of the control word at 0x00) set, the count advances by one every (divider + 1) clock cycles. With it clear, the count holds and the prescaler phase returns to zero.
- R3: The divider register at 0x28 keeps only the low 16 bits of a written word and reads them back zero-extended.
- R4: A write to the status word at 0x10 stores the AND of the written value with the current flags. Only the update event sets bit 0, and a clearing write in the same cycle as an update event leaves bit 0 set.
- R5: On an advancing cycle where the count equals a non-zero reload value (0x2C), the count becomes zero on the next edge. If bit 0 of the interrupt-enable word at 0x0C is also set, status bit 0 is set on that edge and the interrupt output is high for exactly the following cycle. The event period is therefore (reload + 1) × (divider + 1) cycles.
- R6: With a reload value of zero, no update event occurs: the count runs freely, the flag stays clear and the interrupt output stays low.
- R7: A write to the event word at 0x14 with bit 0 set clears the count and the prescaler phase on that edge. A write with bit 0 clear leaves counting undisturbed. The written word is stored and read back.
- R8: A write to the count register at 0x24 loads the written value, overriding an advance in the same cycle, and restarts the prescaler phase. Counting continues from the loaded value.
- R9: A divider write keeps the current count and restarts the prescaler phase, so only the rate of later advances changes.
- R10: Reads of offsets outside the map (including 0x30, 0x44 and anything past 0x50) return zero, and writes there change no register.
- R11: The holding registers read back the last written word. They are at 0x04, 0x08, 0x18, 0x1C, 0x20, the compare words at 0x34, 0x38, 0x3C and 0x40, and 0x48, 0x4C and 0x50.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| upd_irq | output | 1 | One-cycle update interrupt pulse |

## Verification
A software clear of the status flag can land on the same clock edge as a hardware update event. A counter load can land on the same edge as a prescaler advance. The bench times a status write of zero so that the write is captured on the exact edge where the count meets the reload limit, and expects the flag to read back as set afterwards. It also loads the count while the counter advances every cycle, and expects the loaded value rather than the loaded value plus one, followed by a normal advance on the next cycle.

// File: rtl/arl_timer_pkg.sv
package arl_timer_pkg;

    localparam int NUM_SLOTS = 16;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    // storage slot indices for plain read/write words
    localparam int SL_CTRL   = 0;
    localparam int SL_CTRL2  = 1;
    localparam int SL_TRIG   = 2;
    localparam int SL_IEN    = 3;
    localparam int SL_EVGEN  = 4;
    localparam int SL_MODE1  = 5;
    localparam int SL_MODE2  = 6;
    localparam int SL_CHEN   = 7;
    localparam int SL_RELOAD = 8;
    localparam int SL_CMP0   = 9;
    localparam int SL_XCFG   = 13;
    localparam int SL_XADDR  = 14;
    localparam int SL_OPT    = 15;

    typedef enum logic [2:0] {
        AK_NONE,
        AK_SLOT,
        AK_STAT,
        AK_CNT,
        AK_DIV
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e           kind;
        logic [SLOT_W-1:0]   slot;
    } dec_t;

    function automatic dec_t slot_hit(input int s);
        dec_t r;
        r.kind = AK_SLOT;
        r.slot = SLOT_W'(s);
        return r;
    endfunction

    function automatic dec_t decode(input logic [31:0] a);
        dec_t r;
        r.kind = AK_NONE;
        r.slot = '0;
        case (a)
            32'h00: r = slot_hit(SL_CTRL);
            32'h04: r = slot_hit(SL_CTRL2);
            32'h08: r = slot_hit(SL_TRIG);
            32'h0C: r = slot_hit(SL_IEN);
            32'h10: r.kind = AK_STAT;
            32'h14: r = slot_hit(SL_EVGEN);
            32'h18: r = slot_hit(SL_MODE1);
            32'h1C: r = slot_hit(SL_MODE2);
            32'h20: r = slot_hit(SL_CHEN);
            32'h24: r.kind = AK_CNT;
            32'h28: r.kind = AK_DIV;
            32'h2C: r = slot_hit(SL_RELOAD);
            32'h48: r = slot_hit(SL_XCFG);
            32'h4C: r = slot_hit(SL_XADDR);
            32'h50: r = slot_hit(SL_OPT);
            default: begin
                if (a >= 32'h34 && a <= 32'h40 && a[1:0] == 2'b00)
                    r = slot_hit(SL_CMP0 + int'((a - 32'h34) >> 2));
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/arl_regbank.sv
module arl_regbank #(
    parameter int N = 16,
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        wr_en,
    input  logic [W-1:0]        wdata,
    output logic [N-1:0][W-1:0] q
);

    logic [N-1:0][W-1:0] bank_d, bank_q;

    for (genvar i = 0; i < N; i++) begin : g_word
        always_comb begin
            bank_d[i] = bank_q[i];
            if (wr_en[i])
                bank_d[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bank_q <= '0;
        else
            bank_q <= bank_d;
    end

    assign q = bank_q;

    // R11: an unwritten word keeps its value
    a_r11_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == '0) |=> $stable(bank_q));

endmodule

// File: rtl/arl_prescaler.sv
module arl_prescaler #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic [PW-1:0] limit,
    output logic          tick
);

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.phase == limit);
        if (!run || restart || tick)
            st_d.phase = '0;
        else
            st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R2: phase never runs past the divider
    a_r2_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase <= limit);

    // R2: a stopped prescaler sits at phase zero
    a_r2_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> st_q.phase == '0);

endmodule

// File: rtl/arl_counter.sv
module arl_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clear,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] reload,
    output logic [CW-1:0] count,
    output logic          wrap
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = tick && !clear && !load && (reload != '0) && (st_q.cnt == reload);
        if (clear)
            st_d.cnt = '0;
        else if (load)
            st_d.cnt = load_val;
        else if (wrap)
            st_d.cnt = '0;
        else if (tick)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign count = st_q.cnt;

    // R2: no advance without a tick or a bus action
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear && !load) |=> $stable(st_q.cnt));

    // R5: an update event returns the count to zero
    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> st_q.cnt == '0);

    // R7: forced clear
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> st_q.cnt == '0);

endmodule

// File: rtl/arl_timer.sv
module arl_timer
    import arl_timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              upd_irq
);

    localparam int AEXT = 32 - ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] flags;
        logic [DIV_W-1:0]  div;
        logic              irq;
    } top_st_t;

    top_st_t st_d, st_q;

    dec_t                          dec;
    logic [NUM_SLOTS-1:0]          slot_we;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] bank_q;
    logic                          run, tick, wrap;
    logic                          cnt_clear, cnt_load, div_wr, pre_restart;
    logic                          upd_set;
    logic [DATA_W-1:0]             count;

    always_comb begin
        dec = decode({{AEXT{1'b0}}, bus_addr});
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_we
        assign slot_we[i] = bus_we && (dec.kind == AK_SLOT) && (dec.slot == SLOT_W'(i));
    end

    arl_regbank #(.N(NUM_SLOTS), .W(DATA_W)) bank_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (slot_we),
        .wdata (bus_wdata),
        .q     (bank_q)
    );

    assign run         = bank_q[SL_CTRL][0];
    assign cnt_clear   = slot_we[SL_EVGEN] && bus_wdata[0];
    assign cnt_load    = bus_we && (dec.kind == AK_CNT);
    assign div_wr      = bus_we && (dec.kind == AK_DIV);
    assign pre_restart = cnt_clear || cnt_load || div_wr;

    arl_prescaler #(.PW(DIV_W)) pre_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (pre_restart),
        .limit   (st_q.div),
        .tick    (tick)
    );

    arl_counter #(.CW(DATA_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clear    (cnt_clear),
        .load     (cnt_load),
        .load_val (bus_wdata),
        .reload   (bank_q[SL_RELOAD]),
        .count    (count),
        .wrap     (wrap)
    );

    always_comb begin
        st_d    = st_q;
        upd_set = wrap && run && bank_q[SL_IEN][0];
        if (bus_we && dec.kind == AK_STAT)
            st_d.flags = st_q.flags & bus_wdata;
        if (upd_set)
            st_d.flags[0] = 1'b1;
        if (div_wr)
            st_d.div = bus_wdata[DIV_W-1:0];
        st_d.irq = upd_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        unique case (dec.kind)
            AK_SLOT: bus_rdata = bank_q[dec.slot];
            AK_STAT: bus_rdata = st_q.flags;
            AK_CNT:  bus_rdata = count;
            AK_DIV:  bus_rdata = {{(DATA_W-DIV_W){1'b0}}, st_q.div};
            default: bus_rdata = '0;
        endcase
    end

    assign upd_irq = st_q.irq;

    // R5: a pulse always comes with the flag raised
    a_r5_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        upd_irq |-> st_q.flags[0]);

    // R5: pulse only when both enables were set
    a_r5_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        upd_irq |-> $past(bank_q[SL_CTRL][0] && bank_q[SL_IEN][0]));

    // R5: pulse lasts one cycle
    a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        upd_irq |=> !upd_irq);

    // R6: zero reload never produces an event
    a_r6_reload_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        upd_irq |-> $past(bank_q[SL_RELOAD]) != '0);

    // R4: the flag rises only through a hardware update
    a_r4_hw_set_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flags[0]) |-> upd_irq);

    // R4: flags other than bit 0 never become set
    a_r4_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flags[DATA_W-1:1] == '0);

endmodule

// File: tb/arl_timer_tb_top.sv
module arl_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        upd_irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    arl_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .upd_irq   (upd_irq)
    );

    localparam logic [7:0] A_CTRL = 8'h00, A_IEN = 8'h0C, A_STAT = 8'h10,
                           A_EVG = 8'h14, A_CNT = 8'h24, A_DIV = 8'h28,
                           A_RLD = 8'h2C;

    // {addr, write value, expected read}
    localparam int NV = 16;
    localparam logic [71:0] VEC [NV] = '{
        {8'h04, 32'h1111_0004, 32'h1111_0004},
        {8'h08, 32'h2222_0008, 32'h2222_0008},
        {8'h18, 32'hA5A5_0018, 32'hA5A5_0018},
        {8'h1C, 32'h5A5A_001C, 32'h5A5A_001C},
        {8'h20, 32'h0000_1111, 32'h0000_1111},
        {8'h34, 32'hC0DE_0001, 32'hC0DE_0001},
        {8'h38, 32'hC0DE_0002, 32'hC0DE_0002},
        {8'h3C, 32'hC0DE_0003, 32'hC0DE_0003},
        {8'h40, 32'hC0DE_0004, 32'hC0DE_0004},
        {8'h48, 32'h0000_0F48, 32'h0000_0F48},
        {8'h4C, 32'h0000_004C, 32'h0000_004C},
        {8'h50, 32'h0000_0003, 32'h0000_0003},
        {8'h2C, 32'h0000_0777, 32'h0000_0777},
        {8'h28, 32'hABCD_1234, 32'h0000_1234},
        {8'h30, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h44, 32'hDEAD_BEEF, 32'h0000_0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int          n_irq;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a <= 'h50; a += 4) begin
            rd(8'(a), v);
            chk($sformatf("R1 reset read 0x%02h", a), v, 32'h0);
        end
        chk("R1 irq low after reset", {31'b0, upd_irq}, 32'h0);

        // R11 / R3 / R10 vector table, counter disabled
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], v);
            chk($sformatf("R11/R3/R10 vector %0d addr 0x%02h", i, VEC[i][71:64]), v, VEC[i][31:0]);
        end
        // R10: unmapped writes did not disturb neighbours
        rd(A_RLD, v);  chk("R10 reload untouched", v, 32'h0000_0777);
        rd(8'h34, v);  chk("R10 compare0 untouched", v, 32'hC0DE_0001);
        rd(8'h40, v);  chk("R10 compare3 untouched", v, 32'hC0DE_0004);
        rd(8'hFC, v);  chk("R10 far unmapped read", v, 32'h0);

        // R2: divider 0, free run
        wr(A_RLD, 32'h0);
        wr(A_DIV, 32'h0);
        wr(A_EVG, 32'h1);
        wr(A_CTRL, 32'h1);
        repeat (5) @(negedge clk);
        rd(A_CNT, v); chk("R2 divider 0 advance", v, 32'd5);
        wr(A_CTRL, 32'h0);
        rd(A_CNT, v); chk("R2 count at stop", v, 32'd7);
        repeat (3) @(negedge clk);
        rd(A_CNT, v); chk("R2 hold while disabled", v, 32'd7);

        // R2: divider 3
        wr(A_EVG, 32'h1);
        wr(A_DIV, 32'h3);
        wr(A_CTRL, 32'h1);
        repeat (7) @(negedge clk);
        rd(A_CNT, v); chk("R2 divider 3 after 7 cycles", v, 32'd1);
        @(negedge clk);
        rd(A_CNT, v); chk("R2 divider 3 after 8 cycles", v, 32'd2);
        wr(A_CTRL, 32'h0);

        // R9: divider write keeps count
        wr(A_CNT, 32'd50);
        wr(A_DIV, 32'h1);
        rd(A_CNT, v); chk("R9 count kept over divider write", v, 32'd50);
        wr(A_CTRL, 32'h1);
        repeat (2) @(negedge clk);
        rd(A_CNT, v); chk("R9 new rate first step", v, 32'd51);
        repeat (2) @(negedge clk);
        rd(A_CNT, v); chk("R9 new rate second step", v, 32'd52);
        wr(A_CTRL, 32'h0);

        // R8: load while advancing every cycle
        wr(A_DIV, 32'h0);
        wr(A_CTRL, 32'h1);
        wr(A_CNT, 32'd100);
        rd(A_CNT, v); chk("R8 load wins over tick", v, 32'd100);
        @(negedge clk);
        rd(A_CNT, v); chk("R8 continues from load", v, 32'd101);

        // R7: forced update
        wr(A_EVG, 32'h1);
        rd(A_CNT, v); chk("R7 event clears count", v, 32'd0);
        rd(A_EVG, v); chk("R7 event word stored", v, 32'h1);
        repeat (3) @(negedge clk);
        wr(A_EVG, 32'h2);
        rd(A_CNT, v); chk("R7 bit0 clear keeps counting", v, 32'd5);

        // R6: zero reload, interrupt enabled
        wr(A_IEN, 32'h1);
        wr(A_EVG, 32'h1);
        n_irq = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (upd_irq) n_irq++;
        end
        chk("R6 no irq with zero reload", n_irq, 0);
        rd(A_CNT, v); chk("R6 free run count", v, 32'd20);
        rd(A_STAT, v); chk("R6 flag clear", v, 32'h0);

        // R5: update event at reload 4
        wr(A_CTRL, 32'h0);
        wr(A_RLD, 32'd4);
        wr(A_EVG, 32'h1);
        wr(A_CTRL, 32'h1);
        repeat (4) @(negedge clk);
        chk("R5 no irq before reload", {31'b0, upd_irq}, 32'h0);
        rd(A_CNT, v); chk("R5 count at reload", v, 32'd4);
        @(negedge clk);
        chk("R5 irq pulse", {31'b0, upd_irq}, 32'h1);
        rd(A_CNT, v); chk("R5 wrap to zero", v, 32'd0);
        rd(A_STAT, v); chk("R5 flag set", v, 32'h1);
        @(negedge clk);
        chk("R5 pulse one cycle", {31'b0, upd_irq}, 32'h0);
        n_irq = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (upd_irq) n_irq++;
        end
        chk("R5 period reload+1", n_irq, 2);

        // R4: clear write colliding with update event
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R4 write zero clears", v, 32'h0);
        wr(A_EVG, 32'h1);
        wr(A_CTRL, 32'h1);
        repeat (3) @(negedge clk);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R4 hardware set wins same cycle", v, 32'h1);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, v); chk("R4 writing one keeps flag", v, 32'h1);
        wr(A_STAT, 32'hFFFF_FFFE);
        rd(A_STAT, v); chk("R4 writing zero in bit0 clears", v, 32'h0);

        // R5: interrupt enable clear gates flag and pulse
        wr(A_IEN, 32'h0);
        wr(A_STAT, 32'h0);
        n_irq = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (upd_irq) n_irq++;
        end
        chk("R5 no irq with enable clear", n_irq, 0);
        rd(A_STAT, v); chk("R5 no flag with enable clear", v, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule